// File: doc/BRIEF.md
# Periodic Interval Timer

This block is a reloadable down-counter that paces itself on a one-cycle tick enable, which arrives at 32768 Hz in the intended system. Software programs a 16-bit reload value through two byte registers, loads the live counter, and sets the run bit. The counter then loses one count per tick. When a count of one is consumed, the counter reaches zero: the block raises a sticky flag and refills the counter from the reload value. In continuous mode it keeps running. In one-shot mode it drops its own run bit. To get a rate of 2^k Hz, program a reload of 0x8000 shifted right by k, which is a single set bit.

Software sees a byte-wide register port. It has a control register, the two reload bytes and the live counter bytes. The flag is cleared by writing a one to it. The interrupt line is the flag gated by an interrupt enable. The control register also holds a watchdog enable bit that is only stored, and a watchdog busy bit that always reads zero.

Top module: `pit_timer`

## Requirements
- R1: After reset, the control register (0x10), both reload bytes (0x12 low, 0x13 high) and both counter bytes (0x20 low, 0x21 high) read 0x00, and irq is low.
- R2: The control register at 0x10 stores bit6 (watchdog enable), bit3 (run), bit2 (interrupt enable) and bit0 (mode, 1 = continuous). Bit1 reads as the flag. Bits 7, 5 and 4 always read 0.
- R3: Bytes written to 0x12 and 0x13 read back unchanged and form the reload value {0x13, 0x12}.
- R4: Any write to 0x20 loads the counter with the reload value, or with 0x10000 when the reload value is 0. Offsets 0x20 and 0x21 read counter bits 7:0 and 15:8, so a counter of 0x10000 reads 0x0000.
- R5: The counter drops by exactly one on each clock cycle where tick_en is high and run is set. It holds when tick_en is low or run is clear.
- R6: A tick that finds the counter at 1 sets the flag and reloads the counter in the same edge. With reload N, the flag rises on the N-th tick after a load.
- R7: With a reload value of 0, one tick after a load the counter reads 0xFFFF.
- R8: Writing 0x10 with bit1 = 1 clears the flag. Writing it with bit1 = 0 leaves the flag unchanged.
- R9: When an expiry and a flag-clearing write fall on the same cycle, the flag ends up set.
- R10: irq is high exactly when both the flag and the interrupt enable are set.
- R11: At expiry in continuous mode, run stays set and counting goes on. At expiry in one-shot mode, run is cleared and the counter then holds its reloaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle count enable (32768 Hz pace) |
| we | input | 1 | Register write strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Register writes and ticks take effect at the clock edge on which they are presented. Read data is a combinational view of the registers, so a written value or a tick result can be read in the cycle after that edge. irq is decoded from the registered flag and enable, so it changes in the same cycle as the flag it follows. The bench drives inputs at the falling edge and samples 1 ns after the next falling edge. Each check therefore sees the state after exactly the edges it has counted, including the edge where a tick and a clearing write coincide.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CTRL   = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_RLD_LO = 8'h12;
    localparam logic [ADDR_W-1:0] OFS_RLD_HI = 8'h13;
    localparam logic [ADDR_W-1:0] OFS_CNT_LO = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_CNT_HI = 8'h21;

    // control bit positions (decoded by software, kept fixed)
    localparam int B_WD_BUSY = 7;
    localparam int B_WD_EN   = 6;
    localparam int B_RUN     = 3;
    localparam int B_IRQ_EN  = 2;
    localparam int B_FLAG    = 1;
    localparam int B_CONT    = 0;

    typedef struct packed {
        logic wd_en;
        logic run;
        logic irq_en;
        logic flag;
        logic cont;
    } ctrl_t;

    typedef struct packed {
        logic wd_en;
        logic run;
        logic irq_en;
        logic flag_clr;
        logic cont;
    } ctrl_wr_t;
endpackage

// File: rtl/pit_downcnt.sv
module pit_downcnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] reload,
    output logic             expire,
    output logic [CNT_W:0]   count
);
    localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};
    localparam logic [CNT_W:0] ONE  = {{CNT_W{1'b0}}, 1'b1};

    typedef struct packed {
        logic [CNT_W:0] cnt;
    } cnt_st_t;

    cnt_st_t        st_d, st_q;
    logic [CNT_W:0] start_val;
    logic           step;

    always_comb begin
        st_d      = st_q;
        start_val = (reload == '0) ? FULL : {1'b0, reload};
        step      = tick && run && !load;
        expire    = step && (st_q.cnt == ONE);
        if (load) begin
            st_d.cnt = start_val;
        end else if (expire) begin
            st_d.cnt = start_val;
        end else if (step) begin
            st_d.cnt = st_q.cnt - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= FULL;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/pit_ctrl.sv
module pit_ctrl
    import pit_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr,
    input  ctrl_wr_t wr_fields,
    input  logic     expire,
    output ctrl_t    ctrl
);
    ctrl_t ctrl_d, ctrl_q;

    always_comb begin
        ctrl_d = ctrl_q;
        if (wr) begin
            ctrl_d.wd_en  = wr_fields.wd_en;
            ctrl_d.run    = wr_fields.run;
            ctrl_d.irq_en = wr_fields.irq_en;
            ctrl_d.cont   = wr_fields.cont;
            if (wr_fields.flag_clr) begin
                ctrl_d.flag = 1'b0;
            end
        end
        // expiry is applied last so that setting beats clearing
        if (expire) begin
            ctrl_d.flag = 1'b1;
            if (!ctrl_q.cont) begin
                ctrl_d.run = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign ctrl = ctrl_q;
endmodule

// File: rtl/pit_regfile.sv
module pit_regfile
    import pit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [DATA_W-1:0]     wdata,
    input  ctrl_t                 ctrl,
    input  logic [2*DATA_W-1:0]   count,
    output logic [DATA_W-1:0]     rdata,
    output logic [2*DATA_W-1:0]   reload,
    output logic                  wr_ctrl,
    output logic                  wr_cnt
);
    typedef struct packed {
        logic [DATA_W-1:0] hi;
        logic [DATA_W-1:0] lo;
    } rld_t;

    rld_t              rld_d, rld_q;
    logic [DATA_W-1:0] ctrl_view;

    always_comb begin
        rld_d   = rld_q;
        wr_ctrl = we && (addr == OFS_CTRL);
        wr_cnt  = we && (addr == OFS_CNT_LO);
        if (we && (addr == OFS_RLD_LO)) begin
            rld_d.lo = wdata;
        end
        if (we && (addr == OFS_RLD_HI)) begin
            rld_d.hi = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rld_q <= '0;
        end else begin
            rld_q <= rld_d;
        end
    end

    always_comb begin
        ctrl_view            = '0;
        ctrl_view[B_WD_BUSY] = 1'b0;
        ctrl_view[B_WD_EN]   = ctrl.wd_en;
        ctrl_view[B_RUN]     = ctrl.run;
        ctrl_view[B_IRQ_EN]  = ctrl.irq_en;
        ctrl_view[B_FLAG]    = ctrl.flag;
        ctrl_view[B_CONT]    = ctrl.cont;
    end

    always_comb begin
        case (addr)
            OFS_CTRL:   rdata = ctrl_view;
            OFS_RLD_LO: rdata = rld_q.lo;
            OFS_RLD_HI: rdata = rld_q.hi;
            OFS_CNT_LO: rdata = count[DATA_W-1:0];
            OFS_CNT_HI: rdata = count[2*DATA_W-1:DATA_W];
            default:    rdata = '0;
        endcase
    end

    assign reload = rld_q;
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    ctrl_t            ctrl_q;
    ctrl_wr_t         wr_fields;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W:0]   cnt_q;
    logic             wr_ctrl, wr_cnt, expire;

    always_comb begin
        wr_fields.wd_en    = wdata[B_WD_EN];
        wr_fields.run      = wdata[B_RUN];
        wr_fields.irq_en   = wdata[B_IRQ_EN];
        wr_fields.flag_clr = wdata[B_FLAG];
        wr_fields.cont     = wdata[B_CONT];
    end

    pit_regfile #(.DATA_W(DATA_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .ctrl    (ctrl_q),
        .count   (cnt_q[CNT_W-1:0]),
        .rdata   (rdata),
        .reload  (reload_q),
        .wr_ctrl (wr_ctrl),
        .wr_cnt  (wr_cnt)
    );

    pit_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (wr_ctrl),
        .wr_fields (wr_fields),
        .expire    (expire),
        .ctrl      (ctrl_q)
    );

    pit_downcnt #(.CNT_W(CNT_W)) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_en),
        .run    (ctrl_q.run),
        .load   (wr_cnt),
        .reload (reload_q),
        .expire (expire),
        .count  (cnt_q)
    );

    assign irq = ctrl_q.flag & ctrl_q.irq_en;
endmodule

// File: rtl/pit_timer_chk.sv
module pit_timer_chk
    import pit_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic              clr_bit,
    input logic              irq,
    input logic              flag,
    input logic              run,
    input logic              cont,
    input logic              expire,
    input logic [CNT_W-1:0]  reload_q,
    input logic [CNT_W:0]    cnt_q
);
    localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

    // R4
    load_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_CNT_LO) |=>
        (cnt_q == (($past(reload_q) == '0) ? FULL : {1'b0, $past(reload_q)})));

    // R5
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !(we && addr == OFS_CNT_LO)) |=> $stable(cnt_q));

    // R6
    flag_on_expiry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> flag);

    // R8
    w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we && addr == OFS_CTRL && clr_bit && !expire) |=> !flag);

    // R11
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !cont) |=> !run);

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ($past(tick_en) || $past(we)));
endmodule

bind pit_timer pit_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .we       (we),
    .addr     (addr),
    .clr_bit  (wdata[1]),
    .irq      (irq),
    .flag     (ctrl_q.flag),
    .run      (ctrl_q.run),
    .cont     (ctrl_q.cont),
    .expire   (expire),
    .reload_q (reload_q),
    .cnt_q    (cnt_q)
);

// File: tb/pit_timer_tb.sv
module pit_timer_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic       we = 1'b0;
    logic [7:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    pit_timer dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .we      (we),
        .addr    (addr),
        .wdata   (wdata),
        .rdata   (rdata),
        .irq     (irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        we = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        we = 1'b0; wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
        @(negedge clk);
        addr = a;
        #1;
        chk(req, rdata, exp);
    endtask

    task automatic ticks(input int n);
        @(negedge clk);
        tick_en = 1'b1;
        repeat (n) @(negedge clk);
        tick_en = 1'b0;
    endtask

    task automatic cnt_chk(input string req, input logic [15:0] exp);
        rd_chk(req, 8'h20, exp[7:0]);
        rd_chk(req, 8'h21, exp[15:8]);
    endtask

    task automatic t_reset;
        rd_chk("R1 ctrl", 8'h10, 8'h00);
        rd_chk("R1 reload lo", 8'h12, 8'h00);
        rd_chk("R1 reload hi", 8'h13, 8'h00);
        cnt_chk("R1 count", 16'h0000);
        chk("R1 irq", irq, 1'b0);
    endtask

    task automatic t_regs;
        wr(8'h10, 8'hFF);
        rd_chk("R2 stored bits only", 8'h10, 8'h4D);
        wr(8'h10, 8'h40);
        rd_chk("R2 watchdog enable", 8'h10, 8'h40);
        wr(8'h10, 8'h00);
        rd_chk("R2 cleared", 8'h10, 8'h00);
        wr(8'h12, 8'h34);
        wr(8'h13, 8'h12);
        rd_chk("R3 reload lo", 8'h12, 8'h34);
        rd_chk("R3 reload hi", 8'h13, 8'h12);
    endtask

    task automatic t_count;
        wr(8'h12, 8'h05);
        wr(8'h13, 8'h00);
        wr(8'h20, 8'h00);
        cnt_chk("R4 load", 16'h0005);
        ticks(3);
        cnt_chk("R5 no run", 16'h0005);
        wr(8'h10, 8'h09);
        repeat (3) @(negedge clk);
        cnt_chk("R5 no tick", 16'h0005);
        ticks(2);
        cnt_chk("R5 two ticks", 16'h0003);
        ticks(2);
        cnt_chk("R5 at one", 16'h0001);
        rd_chk("R6 no flag yet", 8'h10, 8'h09);
        ticks(1);
        rd_chk("R6 flag set", 8'h10, 8'h0B);
        cnt_chk("R6 reloaded", 16'h0005);
        chk("R10 irq masked", irq, 1'b0);
        wr(8'h10, 8'h0D);
        rd_chk("R8 zero keeps flag", 8'h10, 8'h0F);
        chk("R10 irq on", irq, 1'b1);
        wr(8'h10, 8'h0F);
        rd_chk("R8 one clears flag", 8'h10, 8'h0D);
        chk("R10 irq off", irq, 1'b0);
        ticks(5);
        rd_chk("R11 continuous keeps run", 8'h10, 8'h0F);
        cnt_chk("R11 continuous reload", 16'h0005);
    endtask

    task automatic t_oneshot;
        wr(8'h10, 8'h06);
        rd_chk("R8 clear with run off", 8'h10, 8'h04);
        wr(8'h12, 8'h03);
        wr(8'h20, 8'h00);
        wr(8'h10, 8'h0C);
        ticks(2);
        chk("R10 no irq before expiry", irq, 1'b0);
        ticks(1);
        rd_chk("R11 one-shot clears run", 8'h10, 8'h06);
        chk("R10 irq one-shot", irq, 1'b1);
        ticks(2);
        cnt_chk("R11 stopped", 16'h0003);
    endtask

    task automatic t_zero;
        wr(8'h10, 8'h02);
        rd_chk("R8 all off", 8'h10, 8'h00);
        wr(8'h12, 8'h00);
        wr(8'h20, 8'h00);
        cnt_chk("R4 zero reload", 16'h0000);
        wr(8'h10, 8'h09);
        ticks(1);
        cnt_chk("R7 wrap", 16'hFFFF);
        rd_chk("R7 no flag", 8'h10, 8'h09);
    endtask

    task automatic t_collide;
        wr(8'h12, 8'h01);
        wr(8'h20, 8'h00);
        @(negedge clk);
        tick_en = 1'b1; we = 1'b1; addr = 8'h10; wdata = 8'h0B;
        @(negedge clk);
        tick_en = 1'b0; we = 1'b0; wdata = '0;
        rd_chk("R9 set wins", 8'h10, 8'h0B);
        cnt_chk("R6 reload one", 16'h0001);
        wr(8'h10, 8'h0B);
        rd_chk("R8 later clear", 8'h10, 8'h09);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_count();
        t_oneshot();
        t_zero();
        t_collide();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule